// File: doc/BRIEF.md
# Logarithmic Funnel Shifter

A purely combinational N-bit shifter that handles all six shift kinds: logical, arithmetic and rotate, each to the left or to the right. It first assembles a (2N-1)-bit staging word from the operand and a fill pattern chosen by the shift kind and direction. It then cuts an N-bit window out of that word. The window's offset is set by the shift amount.

The window is chosen by log2(N) ranks of 2:1 multiplexers. Rank s moves the word down by 2^s positions when bit s of the offset is set, so the shift amount is never decoded. A right shift uses the amount itself as the offset. A left shift puts the operand in the upper part of the staging word and uses the bitwise inverse of the amount, which equals N-1-k. Each rank is exactly as wide as the bits it still has to carry, so the last rank is N bits wide.

Top module: `funnel_shifter`

## Requirements
- R1: With amount 0, the output equals the operand for every kind code and both directions.
- R2: Kind code 2'b00 with `go_left`=0 is a logical right shift: the output is the operand moved down by `amount`, and the vacated high bits are 0.
- R3: Kind code 2'b01 with `go_left`=0 is an arithmetic right shift: the vacated high bits are copies of operand bit N-1.
- R4: Kind code 2'b10 with `go_left`=0 is a right rotate: the bits that leave at the bottom re-enter at the top, and no bit is lost.
- R5: Kind code 2'b00 with `go_left`=1 is a logical left shift: the output is the operand moved up by `amount`, and the vacated low bits are 0.
- R6: Kind code 2'b01 with `go_left`=1 gives the same result as the logical left shift.
- R7: Kind code 2'b10 with `go_left`=1 is a left rotate: the bits that leave at the top re-enter at the bottom.
- R8: Kind code 2'b11 behaves as a logical shift in both directions.
- R9: The output follows the inputs without a clock. With all inputs at 0, the output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand | input | N | Data word to be shifted |
| go_left | input | 1 | 1 = shift or rotate toward the MSB, 0 = toward the LSB |
| kind | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 logical |
| amount | input | log2(N) | Shift distance k, 0 to N-1 |
| result | output | N | Shifted word |

## Verification
The operand patterns are chosen to separate the fill rules from one another:
- 8'hB2 has a set MSB and mixed low bits. It separates zero fill from sign fill and shows where wrapped bits land.
- 8'h7F and 8'h80 drive the sign copy to both polarities at the largest amount.
- 8'h01 and 8'hFF expose an off-by-one in the window offset at the edges.

Each pattern is swept over every amount, every kind code and both directions against a model built from plain shift operators. A short literal table pins down hand-worked cases at amounts 0, 1, 3 and N-1.

// File: rtl/funnel_shifter.sv
module funnel_shifter #(
  parameter int N = 32,
  localparam int LG = $clog2(N)
) (
  input  logic [N-1:0]  operand,
  input  logic          go_left,
  input  logic [1:0]    kind,
  input  logic [LG-1:0] amount,
  output logic [N-1:0]  result
);

  localparam int ZW = 2*N - 1;
  localparam logic [1:0] K_ARITH  = 2'b01;
  localparam logic [1:0] K_ROTATE = 2'b10;

  initial begin
    a_pow2_width: assert (N >= 2 && (1 << LG) == N)
      else $error("N must be a power of two and at least 2");
  end

  logic [N-2:0]  fill_hi, fill_lo;
  logic [ZW-1:0] stage_in;
  logic [LG-1:0] offset;

  always_comb begin
    case (kind)
      K_ARITH:  fill_hi = {(N-1){operand[N-1]}};
      K_ROTATE: fill_hi = operand[N-2:0];
      default:  fill_hi = '0;
    endcase
  end

  assign fill_lo  = (kind == K_ROTATE) ? operand[N-1:1] : '0;
  assign stage_in = go_left ? {operand, fill_lo} : {fill_hi, operand};
  assign offset   = go_left ? ~amount : amount;

  for (genvar s = 0; s < LG; s++) begin : g_rank
    localparam int WI = ZW - ((1 << s) - 1);
    localparam int WO = WI - (1 << s);
    logic [WI-1:0] vin;
    logic [WO-1:0] vout;
    if (s == 0) begin : g_first
      assign vin = stage_in;
    end else begin : g_next
      assign vin = g_rank[s-1].vout;
    end
    for (genvar i = 0; i < WO; i++) begin : g_bit
      assign vout[i] = offset[s] ? vin[i + (1 << s)] : vin[i];
    end
  end

  assign result = g_rank[LG-1].vout;

  logic [N-1:0] keep_r, keep_l;
  assign keep_r = {N{1'b1}} >> amount;
  assign keep_l = {N{1'b1}} << amount;

  always_comb begin
    if (amount == '0)
      a_r1_zero_amount_identity: assert (result == operand);
    if (!go_left && kind != K_ARITH && kind != K_ROTATE)
      a_r2_right_zero_fill: assert ((result & ~keep_r) == '0);
    if (!go_left && kind == K_ARITH)
      a_r3_right_sign_fill: assert ((result & ~keep_r) == (operand[N-1] ? ~keep_r : '0));
    if (kind == K_ROTATE)
      a_r4_r7_rotate_keeps_ones: assert ($countones(result) == $countones(operand));
    if (go_left && kind != K_ROTATE)
      a_r5_r6_left_zero_fill: assert ((result & ~keep_l) == '0);
  end

endmodule

// File: tb/funnel_shifter_bench.sv
module funnel_shifter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int LG = 3;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [N-1:0]  operand = '0;
  logic          go_left = 1'b0;
  logic [1:0]    kind = 2'b00;
  logic [LG-1:0] amount = '0;
  logic [N-1:0]  result;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  funnel_shifter #(.N(N)) u_funnel_shifter (
    .operand(operand), .go_left(go_left), .kind(kind),
    .amount(amount), .result(result)
  );

  // {operand, go_left, kind, amount, expected}
  localparam int NV = 13;
  localparam logic [21:0] VEC [NV] = '{
    {8'hB2, 1'b0, 2'b00, 3'd3, 8'h16},
    {8'hB2, 1'b0, 2'b01, 3'd3, 8'hF6},
    {8'hB2, 1'b0, 2'b10, 3'd3, 8'h56},
    {8'hB2, 1'b1, 2'b00, 3'd3, 8'h90},
    {8'hB2, 1'b1, 2'b01, 3'd3, 8'h90},
    {8'hB2, 1'b1, 2'b10, 3'd3, 8'h95},
    {8'hB2, 1'b0, 2'b10, 3'd0, 8'hB2},
    {8'hB2, 1'b0, 2'b11, 3'd1, 8'h59},
    {8'hB2, 1'b1, 2'b11, 3'd1, 8'h64},
    {8'h7F, 1'b0, 2'b01, 3'd7, 8'h00},
    {8'h80, 1'b0, 2'b01, 3'd7, 8'hFF},
    {8'h7F, 1'b1, 2'b00, 3'd7, 8'h80},
    {8'h7F, 1'b0, 2'b10, 3'd7, 8'hFE}
  };

  function automatic logic [N-1:0] model(input logic [N-1:0] d, input logic l,
                                         input logic [1:0] k, input int a);
    logic [2*N-1:0] dd;
    dd = {d, d};
    if (k == 2'b10) begin
      if (l) begin
        dd = dd << a;
        return dd[2*N-1:N];
      end
      dd = dd >> a;
      return dd[N-1:0];
    end
    if (l) return d << a;
    if (k == 2'b01) return N'($signed(d) >>> a);
    return d >> a;
  endfunction

  function automatic string tag(input logic l, input logic [1:0] k, input int a);
    if (a == 0) return "R1";
    if (k == 2'b11) return "R8";
    if (!l) return (k == 2'b00) ? "R2" : (k == 2'b01) ? "R3" : "R4";
    return (k == 2'b00) ? "R5" : (k == 2'b01) ? "R6" : "R7";
  endfunction

  task automatic check(input string req, input logic [N-1:0] exp);
    n_run++;
    if (result !== exp) begin
      n_fail++;
      $display("FAIL %s: operand=%h left=%0b kind=%0d amount=%0d got %h expected %h",
               req, operand, go_left, kind, amount, result, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] d, input logic l, input logic [1:0] k,
                       input logic [LG-1:0] a);
    @(negedge clk);
    operand = d; go_left = l; kind = k; amount = a;
    #1;
  endtask

  localparam logic [N-1:0] PATS [6] = '{8'hB2, 8'h7F, 8'h80, 8'h01, 8'hFF, 8'h5A};

  initial begin
    @(negedge clk);
    #1;
    check("R9 all-zero inputs", 8'h00);

    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][21:14], VEC[v][13], VEC[v][12:11], VEC[v][10:8]);
      check(tag(VEC[v][13], VEC[v][12:11], int'(VEC[v][10:8])), VEC[v][7:0]);
    end

    for (int p = 0; p < 6; p++)
      for (int l = 0; l < 2; l++)
        for (int k = 0; k < 4; k++)
          for (int a = 0; a < N; a++) begin
            apply(PATS[p], l[0], k[1:0], a[LG-1:0]);
            check(tag(l[0], k[1:0], a), model(PATS[p], l[0], k[1:0], a));
          end

    // R9: output tracks a change with no clock edge in between
    operand = 8'hB2; go_left = 1'b1; kind = 2'b10; amount = 3'd3;
    #1;
    check("R9 comb update", 8'h95);
    amount = 3'd0;
    #1;
    check("R1 back to identity", 8'hB2);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule